// File: doc/BRIEF.md
# Next-PC Instruction Fetch Unit

This block owns the program counter of a single-cycle processor and works out the counter's next value once per clock. The current counter value leaves the block as the instruction memory address. Each cycle the counter either advances by one word, takes a PC-relative conditional branch, or takes a region-relative jump whose low 28 bits come from the instruction.

The surrounding decoder tells the block only that the present instruction is a branch or a jump; whether a branch is taken is settled inside the block by combining the branch flag with the equality result the ALU has already produced. The offset for a branch is measured from the address of the following instruction, not from the branch itself. A jump keeps the top four counter bits and replaces everything below them with the target field followed by two zero bits. The block has no memory, no decoder and no comparator of its own.

Top module: `nextpc_fetch_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counter becomes 0x00000000 on that edge, whatever the other inputs are.
- R2: When `is_jump` is 0 and the branch is not taken, the counter advances by 4 on each rising edge, wrapping from 0xFFFFFFFC to 0x00000000.
- R3: When `is_branch` and `alu_zero` are both 1 and `is_jump` is 0, the new counter is (old counter + 4) plus the 16-bit offset `imm_off` read as two's complement and multiplied by 4.
- R4: `alu_zero` alone, with `is_branch` at 0, has no effect: the counter advances by 4; `is_branch` with `alu_zero` at 0 likewise advances by 4.
- R5: When `is_jump` is 1, the new counter is formed from old counter bits 31..28 in bits 31..28, `jmp_tgt` in bits 27..2, and zeros in bits 1..0.
- R6: When `is_jump` is 1 together with a taken branch, the jump wins.
- R7: The upper four bits kept by a jump are those of the counter value present before the edge, so a jump never leaves the current 256 MB region.
- R8: Counter bits 1..0 are always zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| is_branch | input | 1 | Present instruction is a conditional branch |
| is_jump | input | 1 | Present instruction is a jump |
| alu_zero | input | 1 | ALU equality result for the present instruction |
| imm_off | input | 16 | Signed branch offset in words |
| jmp_tgt | input | 26 | Jump target field in words |
| pc_addr | output | 32 | Current program counter, instruction memory address |

## Verification
The hardest situations to reach from the ports are a counter whose upper four bits are not zero, needed to show that a jump keeps its region, and the wrap of sequential advance past the top of the address space. Both start from a reset value of zero, where jumps only reach region zero and branches only move about 128 KB. The bench gets there with a backward branch from address zero with offset -2, landing on 0xFFFFFFFC, then advances once to see the wrap, branches back up again and only then jumps, so the region kept is 0xF.

// File: rtl/pcu_pkg.sv
// Package pcu_pkg
// Shared defaults and the encoding of the next-counter source for the
// next-PC fetch unit. Assumes byte addressing with 4-byte instructions.
package pcu_pkg;

    parameter int unsigned PCU_ADDR_W = 32;
    parameter int unsigned PCU_IMM_W  = 16;
    parameter int unsigned PCU_TGT_W  = 26;

    // Which path supplies the next counter value.
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } next_src_e;

endpackage

// File: rtl/pcu_seq_adder.sv
// Module pcu_seq_adder
// Adds one instruction word (4 bytes) to the current counter. The carry out
// of the top bit is dropped, so the address space wraps.
module pcu_seq_adder #(
    parameter int unsigned ADDR_W = pcu_pkg::PCU_ADDR_W
) (
    input  logic [ADDR_W-1:0] pc_cur,
    output logic [ADDR_W-1:0] pc_seq
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    // Sequential address of the following instruction.
    always_comb begin
        pc_seq = pc_cur + WORD_BYTES;
    end

endmodule

// File: rtl/pcu_branch_target.sv
// Module pcu_branch_target
// Forms the taken-branch address from the already advanced counter: the
// signed word offset is sign-extended and scaled to bytes, then added.
// Assumes ADDR_W > IMM_W + 2.
module pcu_branch_target #(
    parameter int unsigned ADDR_W = pcu_pkg::PCU_ADDR_W,
    parameter int unsigned IMM_W  = pcu_pkg::PCU_IMM_W
) (
    input  logic [ADDR_W-1:0] pc_seq,
    input  logic [IMM_W-1:0]  imm_off,
    output logic [ADDR_W-1:0] pc_branch
);

    localparam int unsigned EXT_W = ADDR_W - IMM_W - 2;

    logic [ADDR_W-1:0] off_bytes;

    // Sign-extend the word offset and convert it to a byte offset.
    always_comb begin
        off_bytes = {{EXT_W{imm_off[IMM_W-1]}}, imm_off, 2'b00};
    end

    // Offset is relative to the following instruction.
    always_comb begin
        pc_branch = pc_seq + off_bytes;
    end

endmodule

// File: rtl/pcu_jump_target.sv
// Module pcu_jump_target
// Builds a region-relative jump address: the kept upper counter bits, the
// word target field, and two zero bits. Assumes ADDR_W = REGION_W + TGT_W + 2.
module pcu_jump_target #(
    parameter int unsigned ADDR_W   = pcu_pkg::PCU_ADDR_W,
    parameter int unsigned TGT_W    = pcu_pkg::PCU_TGT_W,
    parameter int unsigned REGION_W = ADDR_W - TGT_W - 2
) (
    input  logic [REGION_W-1:0] pc_region,
    input  logic [TGT_W-1:0]    jmp_tgt,
    output logic [ADDR_W-1:0]   pc_jump
);

    // Concatenate region, target and byte offset zero.
    always_comb begin
        pc_jump = {pc_region, jmp_tgt, 2'b00};
    end

endmodule

// File: rtl/pcu_next_sel.sv
// Module pcu_next_sel
// Decides which path drives the next counter value and muxes it. A branch is
// taken only when the branch flag and the zero flag are both set; a jump
// overrides any branch.
module pcu_next_sel #(
    parameter int unsigned ADDR_W = pcu_pkg::PCU_ADDR_W
) (
    input  logic              is_branch,
    input  logic              is_jump,
    input  logic              alu_zero,
    input  logic [ADDR_W-1:0] pc_seq,
    input  logic [ADDR_W-1:0] pc_branch,
    input  logic [ADDR_W-1:0] pc_jump,
    output logic [ADDR_W-1:0] pc_next
);

    import pcu_pkg::*;

    next_src_e src;

    // Pick the source: jump first, then a taken branch, else sequential.
    always_comb begin
        if (is_jump) begin
            src = SRC_JUMP;
        end else if (is_branch && alu_zero) begin
            src = SRC_BRANCH;
        end else begin
            src = SRC_SEQ;
        end
    end

    // Route the selected candidate address.
    always_comb begin
        unique case (src)
            SRC_JUMP:   pc_next = pc_jump;
            SRC_BRANCH: pc_next = pc_branch;
            default:    pc_next = pc_seq;
        endcase
    end

endmodule

// File: rtl/nextpc_fetch_unit.sv
// Module nextpc_fetch_unit
// Holds the program counter and loads the next value on each rising edge.
// Assumes the zero flag and the instruction fields are valid for the whole
// cycle. Reset is synchronous and active low and clears the counter.
module nextpc_fetch_unit #(
    parameter int unsigned ADDR_W = pcu_pkg::PCU_ADDR_W,
    parameter int unsigned IMM_W  = pcu_pkg::PCU_IMM_W,
    parameter int unsigned TGT_W  = pcu_pkg::PCU_TGT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_branch,
    input  logic              is_jump,
    input  logic              alu_zero,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [TGT_W-1:0]  jmp_tgt,
    output logic [ADDR_W-1:0] pc_addr
);

    localparam int unsigned REGION_W = ADDR_W - TGT_W - 2;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_seq;
    logic [ADDR_W-1:0] pc_branch;
    logic [ADDR_W-1:0] pc_jump;
    logic [ADDR_W-1:0] pc_next;

    pcu_seq_adder #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .pc_cur (pc_q),
        .pc_seq (pc_seq)
    );

    pcu_branch_target #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) u_br (
        .pc_seq    (pc_seq),
        .imm_off   (imm_off),
        .pc_branch (pc_branch)
    );

    pcu_jump_target #(
        .ADDR_W   (ADDR_W),
        .TGT_W    (TGT_W),
        .REGION_W (REGION_W)
    ) u_jmp (
        .pc_region (pc_q[ADDR_W-1 -: REGION_W]),
        .jmp_tgt   (jmp_tgt),
        .pc_jump   (pc_jump)
    );

    pcu_next_sel #(
        .ADDR_W (ADDR_W)
    ) u_sel (
        .is_branch (is_branch),
        .is_jump   (is_jump),
        .alu_zero  (alu_zero),
        .pc_seq    (pc_seq),
        .pc_branch (pc_branch),
        .pc_jump   (pc_jump),
        .pc_next   (pc_next)
    );

    // Program counter register: clear on reset, else take the next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_addr = pc_q;

endmodule

// File: rtl/nextpc_fetch_checker.sv
// Module nextpc_fetch_checker
// Property checks on the fetch unit's ports, bound to every instance.
// A flag marks the first reset so nothing is judged on pre-reset values.
module nextpc_fetch_checker #(
    parameter int unsigned ADDR_W = pcu_pkg::PCU_ADDR_W,
    parameter int unsigned IMM_W  = pcu_pkg::PCU_IMM_W,
    parameter int unsigned TGT_W  = pcu_pkg::PCU_TGT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              is_branch,
    input logic              is_jump,
    input logic              alu_zero,
    input logic [IMM_W-1:0]  imm_off,
    input logic [TGT_W-1:0]  jmp_tgt,
    input logic [ADDR_W-1:0] pc_addr
);

    localparam int unsigned REGION_W = ADDR_W - TGT_W - 2;
    localparam int unsigned EXT_W    = ADDR_W - IMM_W - 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic seen_rst;

    // Remember that a reset edge has occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rst <= 1'b1;
        end else if (seen_rst !== 1'b1) begin
            seen_rst <= 1'b0;
        end
    end

    // R1: a reset edge clears the counter.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> pc_addr == '0);

    // R2, R4: no jump and no taken branch means advance by one word.
    a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst === 1'b1 && !is_jump && !(is_branch && alu_zero))
        |=> pc_addr == $past(pc_addr) + STEP);

    // R3: taken branch is relative to the following instruction.
    a_r3_branch_rel: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst === 1'b1 && !is_jump && is_branch && alu_zero)
        |=> pc_addr == $past(pc_addr) + STEP
                       + {{EXT_W{$past(imm_off[IMM_W-1])}}, $past(imm_off), 2'b00});

    // R5, R6: a jump loads the target field regardless of the branch inputs.
    a_r5_jump_field: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst === 1'b1 && is_jump)
        |=> pc_addr[ADDR_W-REGION_W-1:2] == $past(jmp_tgt));

    // R7: a jump keeps the region bits of the counter before the edge.
    a_r7_region_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst === 1'b1 && is_jump)
        |=> pc_addr[ADDR_W-1 -: REGION_W] == $past(pc_addr[ADDR_W-1 -: REGION_W]));

    // R8: the counter stays word aligned after reset.
    a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst === 1'b1 |=> pc_addr[1:0] == 2'b00);

endmodule

bind nextpc_fetch_unit nextpc_fetch_checker #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .TGT_W  (TGT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_branch (is_branch),
    .is_jump   (is_jump),
    .alu_zero  (alu_zero),
    .imm_off   (imm_off),
    .jmp_tgt   (jmp_tgt),
    .pc_addr   (pc_addr)
);

// File: tb/tb_nextpc_fetch_unit.sv
// Bench for nextpc_fetch_unit: a vector table walked from reset, then
// directed runs for reset priority, backward wrap and upper-region jumps.
module tb_nextpc_fetch_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        is_branch;
    logic        is_jump;
    logic        alu_zero;
    logic [15:0] imm_off;
    logic [25:0] jmp_tgt;
    logic [31:0] pc_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    nextpc_fetch_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_branch (is_branch),
        .is_jump   (is_jump),
        .alu_zero  (alu_zero),
        .imm_off   (imm_off),
        .jmp_tgt   (jmp_tgt),
        .pc_addr   (pc_addr)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    typedef struct packed {
        logic        br;
        logic        jp;
        logic        zf;
        logic [15:0] imm;
        logic [25:0] tgt;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    // Expected values worked by hand from the requirements, starting at 0.
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h0000_0004, 4'd2}, // R2
        '{1'b1, 1'b0, 1'b0, 16'h0005, 26'h0000000, 32'h0000_0008, 4'd4}, // R4 branch, zero low
        '{1'b0, 1'b0, 1'b1, 16'h0005, 26'h0000000, 32'h0000_000C, 4'd4}, // R4 zero only
        '{1'b1, 1'b0, 1'b1, 16'h0003, 26'h0000000, 32'h0000_001C, 4'd3}, // R3 forward
        '{1'b1, 1'b0, 1'b1, 16'hFFFF, 26'h0000000, 32'h0000_001C, 4'd3}, // R3 offset -1
        '{1'b0, 1'b1, 1'b0, 16'h0000, 26'h0000100, 32'h0000_0400, 4'd5}, // R5
        '{1'b1, 1'b1, 1'b1, 16'h0007, 26'h0000040, 32'h0000_0100, 4'd6}, // R6
        '{1'b1, 1'b0, 1'b1, 16'h7FFF, 26'h0000000, 32'h0002_0100, 4'd3}, // R3 max
        '{1'b1, 1'b0, 1'b1, 16'h8000, 26'h0000000, 32'h0000_0104, 4'd3}, // R3 min
        '{1'b0, 1'b1, 1'b0, 16'h0000, 26'h3FFFFFF, 32'h0FFF_FFFC, 4'd5}, // R5 all ones
        '{1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h1000_0000, 4'd2}  // R2 carry
    };

    task automatic check(input logic [31:0] exp, input string req);
        n_cmp++;
        if (pc_addr !== exp) begin
            n_bad++;
            $display("FAIL %s: pc_addr=%h expected=%h", req, pc_addr, exp);
        end
        n_cmp++;
        if (pc_addr[1:0] !== 2'b00) begin
            n_bad++;
            $display("FAIL R8: low bits=%b expected=00", pc_addr[1:0]);
        end
    endtask

    // Apply inputs at a falling edge, let one rising edge pass, land on the next fall.
    task automatic step(input logic br, input logic jp, input logic zf,
                        input logic [15:0] imm, input logic [25:0] tgt);
        is_branch = br;
        is_jump   = jp;
        alu_zero  = zf;
        imm_off   = imm;
        jmp_tgt   = tgt;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b1, 16'h1234, 26'h3ABCDEF);
        step(1'b0, 1'b1, 1'b0, 16'h0000, 26'h1111111);
        check(32'h0, "R1 reset with jump driven");
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        is_branch = 1'b0;
        is_jump = 1'b0;
        alu_zero = 1'b0;
        imm_off = '0;
        jmp_tgt = '0;
        @(negedge clk);
        do_reset();

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].br, VEC[i].jp, VEC[i].zf, VEC[i].imm, VEC[i].tgt);
            check(VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
        end

        // R1: reset from a nonzero counter.
        do_reset();

        // R3 backward from zero: 0 + 4 - 8 = 0xFFFFFFFC.
        step(1'b1, 1'b0, 1'b1, 16'hFFFE, 26'h0);
        check(32'hFFFF_FFFC, "R3 backward to top");
        // R2 wrap past the top.
        step(1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        check(32'h0000_0000, "R2 wrap");
        step(1'b1, 1'b0, 1'b1, 16'hFFFE, 26'h0);
        check(32'hFFFF_FFFC, "R3 backward again");
        // R7: jump keeps region 0xF.
        step(1'b0, 1'b1, 1'b0, 16'h0, 26'h0000010);
        check(32'hF000_0040, "R7 region kept");
        // R6 with a taken branch in region 0xF.
        step(1'b1, 1'b1, 1'b1, 16'h0100, 26'h0000020);
        check(32'hF000_0080, "R6 jump over branch");
        step(1'b0, 1'b0, 1'b1, 16'h0100, 26'h0);
        check(32'hF000_0084, "R4 zero only in high region");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule